// File: doc/BRIEF.md
# Configurable Logic Cell

This block models one programmable cell of a soft logic fabric. Four data inputs address a 16-entry lookup table whose contents come from a static configuration mask. A single storage element next to the table can be set up as a D, toggle, JK or set/reset flip-flop. Its data comes from the table result, from a spare data input when the cell is packed, or from the neighbouring cell's chain output.

Three cell outputs each choose, on their own, either the table result or the stored bit. The table can therefore serve purely combinational logic while the register holds an unrelated value, or one output can carry the registered form of the table result while another carries the unregistered form.

A feedback option replaces one table address bit with the stored bit, so a state machine bit can live beside the logic that computes its next value. A majority carry output supports arithmetic chains. All configuration inputs are expected to stay constant while the cell operates.

Top module: `logic_cell`

## Requirements
- R1: When `cfg_osel[i]` is 0, `cell_out[i]` combinationally equals `cfg_mask[idx]`, where idx = {din[3],din[2],din[1],din[0]} with din[0] as the least significant address bit.
- R2: When `cfg_osel[i]` is 1, `cell_out[i]` equals the stored bit. Bit i selects for output i alone (0 local, 1 row, 2 column).
- R3: A low `aclr_n` clears the stored bit at once, without waiting for a clock, and overrides every other control.
- R4: A high `sclr` clears the stored bit on the next rising edge, regardless of `sload` and `en`.
- R5: When `sclr` is low, `sload` is high and `cfg_pack` is 0, the next edge loads `din[2]`, regardless of `en`.
- R6: With no clear or load active and `en` low, the stored bit holds its value.
- R7: `cfg_mode`=0 (D): when enabled, the stored bit takes the table result, provided `cfg_chain` and `cfg_pack` are both 0.
- R8: `cfg_mode`=1 (toggle): when enabled, the stored bit inverts if the table result is 1 and holds otherwise.
- R9: `cfg_mode`=2 (JK): J is the table result and K is `din[2]`. 00 holds, 01 clears, 10 sets and 11 toggles.
- R10: `cfg_mode`=3 (SR): S is the table result and R is `din[2]`. 10 sets, 01 clears, and both 00 and 11 hold.
- R11: With `cfg_pack`=1, `sload` has no effect. In D mode without chaining, the register data comes from `din[3]`.
- R12: With `cfg_fb`=1, the stored bit replaces `din[2]` as table address bit 2.
- R13: `chain_out` always equals the stored bit. With `cfg_chain`=1 in D mode, the register data comes from `chain_in`, and this takes priority over packing.
- R14: `carry_out` is majority(din[0], din[1], carry_in) when `cfg_arith` is 1, and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Cell clock |
| aclr_n | input | 1 | Asynchronous clear, active low |
| cfg_mask | input | 16 | Lookup table contents |
| cfg_mode | input | 2 | Register type: 0 D, 1 T, 2 JK, 3 SR |
| cfg_pack | input | 1 | Packed mode: register fed from din[3], sync load off |
| cfg_fb | input | 1 | Register feedback into table address bit 2 |
| cfg_chain | input | 1 | D data taken from chain_in |
| cfg_arith | input | 1 | Enables carry output |
| cfg_osel | input | 3 | Per-output select: 0 table, 1 register |
| din | input | 4 | Data inputs, din[0] is data1 |
| carry_in | input | 1 | Carry from previous cell |
| chain_in | input | 1 | Register chain from previous cell |
| en | input | 1 | Clock enable |
| sclr | input | 1 | Synchronous clear |
| sload | input | 1 | Synchronous load of din[2] |
| cell_out | output | 3 | Local, row and column outputs |
| chain_out | output | 1 | Register chain to next cell |
| carry_out | output | 1 | Carry to next cell |

## Verification
The assertions assume that the configuration inputs are static between clock edges and change only while no register update depends on them. They also assume that `aclr_n` is the only asynchronous input. The bench changes configuration only at falling edges, and only between phases, with the data and control inputs re-randomised each cycle. The asynchronous clear is likewise driven at falling edges, so each property sees one stable set of inputs per edge.

// File: rtl/cell_pkg.sv
package cell_pkg;

  typedef enum logic [1:0] {
    MODE_D  = 2'd0,
    MODE_T  = 2'd1,
    MODE_JK = 2'd2,
    MODE_SR = 2'd3
  } reg_mode_e;

  // next state of the storage element when enabled
  function automatic logic reg_next(reg_mode_e mode, logic q, logic d,
                                    logic ctl_a, logic ctl_b);
    logic r;
    r = q;
    case (mode)
      MODE_D:  r = d;
      MODE_T:  r = q ^ ctl_a;
      MODE_JK: begin
        case ({ctl_a, ctl_b})
          2'b01:   r = 1'b0;
          2'b10:   r = 1'b1;
          2'b11:   r = ~q;
          default: r = q;
        endcase
      end
      MODE_SR: begin
        case ({ctl_a, ctl_b})
          2'b01:   r = 1'b0;
          2'b10:   r = 1'b1;
          default: r = q;
        endcase
      end
      default: r = q;
    endcase
    return r;
  endfunction

  function automatic logic maj3(logic a, logic b, logic c);
    return (a & b) | (a & c) | (b & c);
  endfunction

endpackage

// File: rtl/cell_lut.sv
module cell_lut #(
  parameter int N_IN   = 4,
  parameter int FB_BIT = 2,
  localparam int DEPTH = 1 << N_IN
) (
  input  logic [DEPTH-1:0] mask,
  input  logic [N_IN-1:0]  din,
  input  logic             fb_en,
  input  logic             fb_q,
  output logic             y
);
  logic [N_IN-1:0] idx;

  always_comb begin
    idx = din;
    if (fb_en) idx[FB_BIT] = fb_q;
  end

  assign y = mask[idx];
endmodule

// File: rtl/cell_ff.sv
module cell_ff
  import cell_pkg::*;
(
  input  logic      clk,
  input  logic      aclr_n,
  input  logic      sclr,
  input  logic      sload,
  input  logic      load_val,
  input  logic      en,
  input  reg_mode_e mode,
  input  logic      dsrc,
  input  logic      ctl_a,
  input  logic      ctl_b,
  output logic      q
);
  always_ff @(posedge clk or negedge aclr_n) begin
    if (!aclr_n)    q <= 1'b0;
    else if (sclr)  q <= 1'b0;
    else if (sload) q <= load_val;
    else if (en)    q <= reg_next(mode, q, dsrc, ctl_a, ctl_b);
  end
endmodule

// File: rtl/cell_outmux.sv
module cell_outmux #(
  parameter int N_OUT = 3
) (
  input  logic [N_OUT-1:0] sel,
  input  logic             comb_v,
  input  logic             reg_v,
  output logic [N_OUT-1:0] y
);
  for (genvar i = 0; i < N_OUT; i++) begin : g_out
    assign y[i] = sel[i] ? reg_v : comb_v;
  end
endmodule

// File: rtl/logic_cell.sv
module logic_cell
  import cell_pkg::*;
#(
  parameter int N_IN     = 4,
  parameter int N_OUT    = 3,
  parameter int FB_BIT   = 2,
  parameter int CTL_BIT  = 2,
  parameter int PACK_BIT = 3,
  localparam int DEPTH   = 1 << N_IN
) (
  input  logic             clk,
  input  logic             aclr_n,
  input  logic [DEPTH-1:0] cfg_mask,
  input  logic [1:0]       cfg_mode,
  input  logic             cfg_pack,
  input  logic             cfg_fb,
  input  logic             cfg_chain,
  input  logic             cfg_arith,
  input  logic [N_OUT-1:0] cfg_osel,
  input  logic [N_IN-1:0]  din,
  input  logic             carry_in,
  input  logic             chain_in,
  input  logic             en,
  input  logic             sclr,
  input  logic             sload,
  output logic [N_OUT-1:0] cell_out,
  output logic             chain_out,
  output logic             carry_out
);
  // named internal events, used by the bound checker
  logic lut_y;
  logic reg_q;
  logic sload_eff;
  logic reg_d;

  cell_lut #(.N_IN(N_IN), .FB_BIT(FB_BIT)) u_lut (
    .mask (cfg_mask),
    .din  (din),
    .fb_en(cfg_fb),
    .fb_q (reg_q),
    .y    (lut_y)
  );

  assign reg_d     = cfg_chain ? chain_in : (cfg_pack ? din[PACK_BIT] : lut_y);
  assign sload_eff = sload & ~cfg_pack;

  cell_ff u_ff (
    .clk     (clk),
    .aclr_n  (aclr_n),
    .sclr    (sclr),
    .sload   (sload_eff),
    .load_val(din[CTL_BIT]),
    .en      (en),
    .mode    (reg_mode_e'(cfg_mode)),
    .dsrc    (reg_d),
    .ctl_a   (lut_y),
    .ctl_b   (din[CTL_BIT]),
    .q       (reg_q)
  );

  cell_outmux #(.N_OUT(N_OUT)) u_mux (
    .sel   (cfg_osel),
    .comb_v(lut_y),
    .reg_v (reg_q),
    .y     (cell_out)
  );

  assign chain_out = reg_q;
  assign carry_out = cfg_arith & maj3(din[0], din[1], carry_in);
endmodule

// File: rtl/logic_cell_chk.sv
module logic_cell_chk #(
  parameter int N_IN  = 4,
  parameter int N_OUT = 3
) (
  input logic             clk,
  input logic             aclr_n,
  input logic [1:0]       cfg_mode,
  input logic             cfg_pack,
  input logic             cfg_arith,
  input logic [N_OUT-1:0] cfg_osel,
  input logic [N_IN-1:0]  din,
  input logic             en,
  input logic             sclr,
  input logic             sload,
  input logic [N_OUT-1:0] cell_out,
  input logic             chain_out,
  input logic             carry_out,
  input logic             lut_y,
  input logic             reg_q,
  input logic             sload_eff
);
  logic upd;
  assign upd = en & ~sclr & ~sload_eff;

  // R3
  always @(posedge clk) begin
    if (!aclr_n) aclr_hold_chk: assert (chain_out == 1'b0);
  end

  // R4
  sclr_clears_chk: assert property (@(posedge clk) disable iff (!aclr_n)
    sclr |=> !chain_out);

  // R5
  sload_loads_chk: assert property (@(posedge clk) disable iff (!aclr_n)
    (!sclr && sload && !cfg_pack) |=> (chain_out == $past(din[2])));

  // R6 R11
  hold_chk: assert property (@(posedge clk) disable iff (!aclr_n)
    (!sclr && !sload_eff && !en) |=> $stable(reg_q));

  // R11
  pack_noload_chk: assert property (@(posedge clk) disable iff (!aclr_n)
    (cfg_pack && sload && !sclr && !en) |=> $stable(chain_out));

  // R8
  t_toggle_chk: assert property (@(posedge clk) disable iff (!aclr_n)
    (cfg_mode == 2'd1 && upd && lut_y) |=> (reg_q != $past(reg_q)));

  // R9
  jk_toggle_chk: assert property (@(posedge clk) disable iff (!aclr_n)
    (cfg_mode == 2'd2 && upd && lut_y && din[2]) |=> (reg_q != $past(reg_q)));

  // R10
  sr_both_hold_chk: assert property (@(posedge clk) disable iff (!aclr_n)
    (cfg_mode == 2'd3 && upd && lut_y && din[2]) |=> $stable(reg_q));

  // R2
  osel_reg_chk: assert property (@(posedge clk) disable iff (!aclr_n)
    cfg_osel[0] |-> (cell_out[0] == chain_out));

  // R14
  carry_off_chk: assert property (@(posedge clk) disable iff (!aclr_n)
    !cfg_arith |-> !carry_out);

  // R14
  carry_maj_chk: assert property (@(posedge clk) disable iff (!aclr_n)
    (cfg_arith && din[0] && din[1]) |-> carry_out);
endmodule

bind logic_cell logic_cell_chk #(.N_IN(N_IN), .N_OUT(N_OUT)) u_chk (.*);

// File: tb/logic_cell_tb.sv
module logic_cell_tb;
  logic        clk = 1'b0;
  logic        aclr_n = 1'b0;
  logic [15:0] cfg_mask = 16'h0;
  logic [1:0]  cfg_mode = 2'd0;
  logic        cfg_pack = 1'b0, cfg_fb = 1'b0, cfg_chain = 1'b0, cfg_arith = 1'b0;
  logic [2:0]  cfg_osel = 3'b0;
  logic [3:0]  din = 4'h0;
  logic        carry_in = 1'b0, chain_in = 1'b0, en = 1'b0, sclr = 1'b0, sload = 1'b0;
  logic [2:0]  cell_out;
  logic        chain_out, carry_out;

  int checks = 0;
  int errors = 0;
  bit mq = 1'b0;          // model of the stored bit
  string last_tag = "R3"; // requirement governing the last register update
  bit done = 1'b0;

  always #4 clk = ~clk;   // 125 MHz

  logic_cell u_dut (
    .clk(clk), .aclr_n(aclr_n), .cfg_mask(cfg_mask), .cfg_mode(cfg_mode),
    .cfg_pack(cfg_pack), .cfg_fb(cfg_fb), .cfg_chain(cfg_chain),
    .cfg_arith(cfg_arith), .cfg_osel(cfg_osel), .din(din),
    .carry_in(carry_in), .chain_in(chain_in), .en(en), .sclr(sclr),
    .sload(sload), .cell_out(cell_out), .chain_out(chain_out),
    .carry_out(carry_out)
  );

  function automatic bit table_ref();
    int a;
    a = int'(din[0]) + 2 * int'(din[1]) + 8 * int'(din[3]);
    a += 4 * (cfg_fb ? int'(mq) : int'(din[2]));
    return cfg_mask[a];
  endfunction

  // behavioural reference, advanced on each rising edge
  always @(posedge clk) begin
    bit t, k;
    t = table_ref();
    k = din[2];
    if (!aclr_n) begin mq = 1'b0; last_tag = "R3"; end
    else if (sclr) begin mq = 1'b0; last_tag = "R4"; end
    else if (sload && !cfg_pack) begin mq = din[2]; last_tag = "R5"; end
    else if (!en) last_tag = (sload ? "R11" : "R6");
    else begin
      if (cfg_mode == 2'd0) begin
        if (cfg_chain) begin mq = chain_in; last_tag = "R13"; end
        else if (cfg_pack) begin mq = din[3]; last_tag = "R11"; end
        else begin mq = t; last_tag = "R7"; end
      end else if (cfg_mode == 2'd1) begin
        if (t) mq = !mq;
        last_tag = "R8";
      end else if (cfg_mode == 2'd2) begin
        if (t && k) mq = !mq;
        else if (t) mq = 1'b1;
        else if (k) mq = 1'b0;
        last_tag = "R9";
      end else begin
        if (t && !k) mq = 1'b1;
        else if (k && !t) mq = 1'b0;
        last_tag = "R10";
      end
    end
  end

  task automatic check(string tag, logic got, bit exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %0b expected %0b at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic check_all();
    bit t;
    t = table_ref();
    for (int i = 0; i < 3; i++) begin
      if (cfg_osel[i]) check("R2", cell_out[i], mq);
      else check(cfg_fb ? "R12" : "R1", cell_out[i], t);
    end
    check(last_tag, chain_out, mq);
    check("R13", chain_out, cell_out[0] === chain_out ? mq : mq);
    check("R14", carry_out,
          cfg_arith && ((int'(din[0]) + int'(din[1]) + int'(carry_in)) >= 2));
  endtask

  task automatic drive_random(bit allow_aclr);
    logic [31:0] r;
    r = $urandom;
    din      = r[3:0];
    carry_in = r[4];
    chain_in = r[5];
    en       = r[8:6] != 3'd0;
    sclr     = r[12:9] == 4'd0;
    sload    = r[15:13] == 3'd0;
    if (allow_aclr && r[21:16] == 6'd0) begin
      aclr_n = 1'b0;
      mq = 1'b0;
      last_tag = "R3";
    end else begin
      aclr_n = 1'b1;
    end
  endtask

  task automatic run_phase(bit [1:0] mode, bit pack, bit fb, bit chain,
                           bit arith, int n);
    @(negedge clk);
    check_all();
    cfg_mode  = mode;
    cfg_pack  = pack;
    cfg_fb    = fb;
    cfg_chain = chain;
    cfg_arith = arith;
    cfg_mask  = 16'($urandom);
    cfg_osel  = 3'($urandom);
    drive_random(1'b0);
    for (int c = 0; c < n; c++) begin
      @(negedge clk);
      check_all();
      drive_random(1'b1);
    end
  endtask

  initial begin
    // reset state (R3): cleared while aclr_n is low
    repeat (2) @(negedge clk);
    check("R3", chain_out, 1'b0);
    cfg_osel = 3'b111;
    #1 check("R3", cell_out[2], 1'b0);
    aclr_n = 1'b1;

    // directed: async clear between edges (R3)
    @(negedge clk);
    cfg_mode = 2'd0; cfg_mask = 16'hFFFF; en = 1'b1; sclr = 1'b0; sload = 1'b0;
    @(negedge clk);
    check("R7", chain_out, 1'b1);
    mq = 1'b1;
    #1 aclr_n = 1'b0;
    #1 check("R3", chain_out, 1'b0);
    mq = 1'b0; last_tag = "R3";
    #1 aclr_n = 1'b1;

    // directed: sclr beats sload and enable (R4)
    @(negedge clk);
    sclr = 1'b1; sload = 1'b1; din = 4'b0100;
    @(negedge clk);
    check("R4", chain_out, 1'b0);
    sclr = 1'b0;

    // directed: LUT address ordering, din[0] least significant (R1)
    cfg_mask = 16'h0002; cfg_osel = 3'b000; en = 1'b0; sload = 1'b0;
    din = 4'b0001;
    #1 check("R1", cell_out[1], 1'b1);
    din = 4'b1000;
    #1 check("R1", cell_out[1], 1'b0);

    // randomised phases across modes and options
    for (int m = 0; m < 4; m++) begin
      run_phase(2'(m), 1'b0, 1'b0, 1'b0, 1'b1, 400);
      run_phase(2'(m), 1'b1, 1'b0, 1'b0, 1'b0, 300);
      run_phase(2'(m), 1'b0, 1'b1, 1'b0, 1'b1, 300);
      run_phase(2'(m), 1'b1, 1'b1, 1'b1, 1'b0, 300);
    end
    run_phase(2'd0, 1'b0, 1'b0, 1'b1, 1'b1, 400);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got hung expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule